// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block adds or subtracts two operands in either full-word or byte width and derives the six conditional status flags of the result: sign, zero, parity, carry, auxiliary carry and overflow. It holds them in a 16-bit status word together with three control flags. Those control flags are single-step, interrupt enable and direction, and software-side logic sets or clears them through dedicated pins. Arithmetic never touches them.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream through a single output register. An input transfer happens on a rising edge where `op_valid` and `op_ready` are both high. That transfer is the only event that updates the conditional flags. `op_ready` is high whenever the output register is empty or is being drained in the same cycle. `op_ready` therefore falls while a result is held against a low `res_ready`, and the held result stays unchanged until it is taken. The status word is a plain output. It always shows the flags of the most recently accepted operation.

Top module: `alu_status_unit`

## Requirements
- R1: On an accepted transfer, `res_data` takes `op_a + op_b` when `op_sub` is 0 and `op_a - op_b` when `op_sub` is 1. Both are modulo 2^16. With `op_byte` = 1 only the low 8 bits of each operand are used, and the result is the 8-bit value zero-extended, with bits 15:8 equal to 0.
- R2: Status bit 7 (sign) equals the most significant result bit, which is bit 15 in word mode and bit 7 in byte mode. Status bit 6 (zero) is 1 exactly when the result is zero over the active width.
- R3: Status bit 2 (parity) is 1 when result bits 7:0 hold an even number of ones, in both modes.
- R4: Status bit 0 (carry) is the carry out of the active MSB for an addition. For a subtraction it is the borrow into the active MSB, which occurs when the unsigned minuend is smaller than the subtrahend.
- R5: Status bit 11 (overflow) is 1 when the signed result over the active width is out of range. That is the case when the carry into the MSB differs from the carry out of it, and the equivalent borrow rule applies for subtraction.
- R6: Status bit 4 (auxiliary carry) is the carry out of bit 3 for an addition and the borrow into bit 3 for a subtraction.
- R7: Status bits 1, 3, 5, 12, 13, 14 and 15 always read 0.
- R8: The conditional flags (bits 0, 2, 4, 6, 7, 11) change only on an edge that accepts an input transfer. With no transfer they hold, whatever the operand pins carry.
- R9: `ctl_set`/`ctl_clr` bit 0 drives status bit 8 (single-step), bit 1 drives status bit 9 (interrupt enable) and bit 2 drives status bit 10 (direction). Each is applied at the next edge, and clear wins when both are high. Arithmetic leaves these bits unchanged.
- R10: `op_ready` is low while `res_valid` is 1 and `res_ready` is 0. During such a stall `res_data` and `res_valid` hold.
- R11: While reset (`rst_n` = 0) is asserted and after it is released, the status word is 0, `res_valid` is 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand transfer offered |
| op_ready | output | 1 | Block can take operands this cycle |
| op_a | input | 16 | First operand (minuend for subtraction) |
| op_b | input | 16 | Second operand (subtrahend for subtraction) |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| op_byte | input | 1 | 1 selects byte width, 0 selects word width |
| res_valid | output | 1 | Result register holds an untaken result |
| res_ready | input | 1 | Downstream takes the result this cycle |
| res_data | output | 16 | Result value |
| ctl_set | input | 3 | Set strobes for the control flags (single-step, interrupt, direction) |
| ctl_clr | input | 3 | Clear strobes for the control flags; clear has priority |
| status_word | output | 16 | Packed status word |

## Verification
On every cycle the assertions check four things. The unused status bits stay zero. The conditional flags hold across cycles without an input transfer. The result holds and input is refused while the output stalls. The control bits obey their set/clear strobes. They also tie the word-mode zero and sign bits and the parity bit to the result that was just registered. The exact carry, borrow, auxiliary and overflow values, the byte-mode width change, zero extension of byte results, and the immunity of the control bits to arithmetic are shown only by the bench scenarios. Those scenarios compare each result against values worked out from the operands with unsigned and signed integer arithmetic, under steady and random back-pressure.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int STAT_W = 16;

  // bit positions inside the status word
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  localparam int CTL_N  = 3;   // single-step, interrupt enable, direction
  localparam int CTL_LO = POS_TF;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } cond_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(cond_flags_t f,
                                                    logic [CTL_N-1:0] ctl);
    logic [STAT_W-1:0] w;
    w = '0;
    w[POS_CF] = f.cry;
    w[POS_PF] = f.par;
    w[POS_AF] = f.aux;
    w[POS_ZF] = f.zer;
    w[POS_SF] = f.sgn;
    w[POS_OF] = f.ovf;
    w[CTL_LO +: CTL_N] = ctl;
    return w;
  endfunction

endpackage

// File: rtl/alu_addsub_core.sv
module alu_addsub_core #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W:0]   carry_o
);

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   c;

  // subtraction as a + ~b + 1
  assign b_eff = b_i ^ {DATA_W{sub_i}};
  assign c[0]  = sub_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
  end

  assign carry_o = c;

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W:0]   carry_i,
  input  logic              sub_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output cond_flags_t       flags_o
);

  localparam int WORD_MSB = DATA_W - 1;
  localparam int BYTE_MSB = BYTE_W - 1;
  localparam int NIB_W    = 4;

  logic msb_bit, cin_msb, cout_msb, nib_carry;

  always_comb begin
    if (byte_i) begin
      res_o    = {{(DATA_W-BYTE_W){1'b0}}, sum_i[BYTE_MSB:0]};
      msb_bit  = sum_i[BYTE_MSB];
      cin_msb  = carry_i[BYTE_MSB];
      cout_msb = carry_i[BYTE_MSB+1];
    end else begin
      res_o    = sum_i;
      msb_bit  = sum_i[WORD_MSB];
      cin_msb  = carry_i[WORD_MSB];
      cout_msb = carry_i[WORD_MSB+1];
    end
    nib_carry = carry_i[NIB_W];

    flags_o.sgn = msb_bit;
    flags_o.zer = (res_o == '0);
    flags_o.par = ~^sum_i[BYTE_MSB:0];
    // inverted carry of a + ~b + 1 is the borrow
    flags_o.cry = cout_msb ^ sub_i;
    flags_o.aux = nib_carry ^ sub_i;
    flags_o.ovf = cin_msb ^ cout_msb;
  end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  cond_flags_t       flags_i,
  input  logic [CTL_N-1:0]  set_i,
  input  logic [CTL_N-1:0]  clr_i,
  output logic [STAT_W-1:0] word_o
);

  cond_flags_t      cond_q;
  logic [CTL_N-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cond_q <= '0;
    else if (load_i) cond_q <= flags_i;
  end

  for (genvar k = 0; k < CTL_N; k++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)        ctl_q[k] <= 1'b0;
      else if (clr_i[k]) ctl_q[k] <= 1'b0;
      else if (set_i[k]) ctl_q[k] <= 1'b1;
    end
  end

  assign word_o = pack_status(cond_q, ctl_q);

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              op_sub,
  input  logic              op_byte,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  output logic [STAT_W-1:0] status_word
);

  logic [DATA_W-1:0] sum_w, res_w;
  logic [DATA_W:0]   carry_w;
  cond_flags_t       flags_w;
  logic              accept;

  assign op_ready = !res_valid || res_ready;
  assign accept   = op_valid && op_ready;

  alu_addsub_core #(.DATA_W(DATA_W)) u_core (
    .a_i     (op_a),
    .b_i     (op_b),
    .sub_i   (op_sub),
    .sum_o   (sum_w),
    .carry_o (carry_w)
  );

  alu_flag_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
    .sum_i   (sum_w),
    .carry_i (carry_w),
    .sub_i   (op_sub),
    .byte_i  (op_byte),
    .res_o   (res_w),
    .flags_o (flags_w)
  );

  alu_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .flags_i (flags_w),
    .set_i   (ctl_set),
    .clr_i   (ctl_clr),
    .word_o  (status_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= res_w;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              op_sub,
  input logic              op_byte,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [CTL_N-1:0]  ctl_set,
  input logic [CTL_N-1:0]  ctl_clr,
  input logic [STAT_W-1:0] status_word
);

  localparam logic [STAT_W-1:0] USED_MASK = 16'h0FD5;

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~USED_MASK) == '0);

  p_cond_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready) |=>
      $stable({status_word[POS_OF], status_word[POS_SF:POS_ZF],
               status_word[POS_AF], status_word[POS_PF], status_word[POS_CF]}));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_stall_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  p_word_zs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_byte) |=>
      (status_word[POS_ZF] == (res_data == '0)) &&
      (status_word[POS_SF] == res_data[DATA_W-1]));

  p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (status_word[POS_PF] == ~^res_data[BYTE_W-1:0]));

  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == '0 && ctl_clr == '0) |=> $stable(status_word[CTL_LO +: CTL_N]));

  p_ctl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr != '0) |=> ((status_word[CTL_LO +: CTL_N] & $past(ctl_clr)) == '0));

  p_ctl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_set & ~ctl_clr) != '0) |=>
      ((status_word[CTL_LO +: CTL_N] & $past(ctl_set & ~ctl_clr)) == $past(ctl_set & ~ctl_clr)));

endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_ready, op_sub, op_byte;
  logic [15:0] op_a, op_b;
  logic        res_valid, res_ready;
  logic [15:0] res_data;
  logic [2:0]  ctl_set, ctl_clr;
  logic [15:0] status_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit rand_bp = 1'b0;
  logic [2:0] ctl_model = 3'b000;

  typedef struct packed {
    logic [15:0] data;
    logic [15:0] cond;
  } exp_t;
  exp_t q[$];
  logic [15:0] last_cond = 16'h0;

  always #10 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .op_byte(op_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .status_word(status_word)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // expected result and conditional status bits from integer arithmetic
  task automatic model(input logic [15:0] a, b, input logic sub, byt,
                       output logic [15:0] r16, output logic [15:0] cond);
    int ua, ub, md, hf, r;
    bit cf, af, of, sa, sb, sr;
    md = byt ? 256 : 65536;
    hf = md / 2;
    ua = byt ? int'(a[7:0]) : int'(a);
    ub = byt ? int'(b[7:0]) : int'(b);
    r  = sub ? (ua - ub + md) % md : (ua + ub) % md;
    cf = sub ? (ua < ub) : (ua + ub >= md);
    af = sub ? ((ua % 16) < (ub % 16)) : ((ua % 16) + (ub % 16) > 15);
    sa = ua >= hf; sb = ub >= hf; sr = r >= hf;
    of = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    r16  = r[15:0];
    cond = 16'h0;
    cond[0]  = cf;
    cond[2]  = ~^r16[7:0];
    cond[4]  = af;
    cond[6]  = (r == 0);
    cond[7]  = sr;
    cond[11] = of;
  endtask

  task automatic send(input logic [15:0] a, b, input logic sub, byt);
    logic rdy;
    exp_t e;
    model(a, b, sub, byt, e.data, e.cond);
    do begin
      @(negedge clk);
      op_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; op_byte = byt;
      #2 rdy = op_ready;
      @(posedge clk);
    end while (!rdy);
    q.push_back(e);
    last_cond = e.cond;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic ctl(input logic [2:0] s, c);
    @(negedge clk);
    ctl_set = s; ctl_clr = c;
    @(posedge clk);
    #1 ctl_model = (ctl_model | s) & ~c;
    @(negedge clk);
    ctl_set = 3'b000; ctl_clr = 3'b000;
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || res_valid) && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  // monitor: compares each result as it leaves the block
  initial begin
    exp_t e;
    logic [15:0] sw;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && res_valid && res_ready) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 got=%h exp=none (unexpected result)", res_data);
        end else begin
          e  = q.pop_front();
          sw = status_word;
          chk("R1 result", res_data, e.data);
          chk("R4 carry", {15'h0, sw[0]}, {15'h0, e.cond[0]});
          chk("R3 parity", {15'h0, sw[2]}, {15'h0, e.cond[2]});
          chk("R6 aux", {15'h0, sw[4]}, {15'h0, e.cond[4]});
          chk("R2 zero/sign", {14'h0, sw[7:6]}, {14'h0, e.cond[7:6]});
          chk("R5 overflow", {15'h0, sw[11]}, {15'h0, e.cond[11]});
          chk("R9 control", {13'h0, sw[10:8]}, {13'h0, ctl_model});
          chk("R7 unused", sw & 16'hF02A, 16'h0);
        end
      end
    end
  end

  // random back-pressure generator
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(negedge clk);
      if (rand_bp) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        res_ready = lf[0] | lf[2];
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held, sw0;
    rst_n = 1'b0; op_valid = 1'b0; op_a = 16'h0; op_b = 16'h0;
    op_sub = 1'b0; op_byte = 1'b0; res_ready = 1'b1;
    ctl_set = 3'b000; ctl_clr = 3'b000;
    repeat (3) @(negedge clk);
    chk("R11 status in reset", status_word, 16'h0);
    chk("R11 valid in reset", {15'h0, res_valid}, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R11 status after reset", status_word, 16'h0);
    chk("R11 ready after reset", {15'h0, op_ready}, 16'h1);

    // word mode
    send(16'h2345, 16'h3219, 1'b0, 1'b0);
    send(16'h5439, 16'h456A, 1'b0, 1'b0);
    send(16'h1234, 16'h4AE0, 1'b1, 1'b0);
    send(16'h70A3, 16'hE757, 1'b1, 1'b0);
    send(16'hFE58, 16'h01A8, 1'b0, 1'b0);
    send(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    send(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    send(16'h8000, 16'h0001, 1'b1, 1'b0);
    send(16'h00FF, 16'h0001, 1'b0, 1'b0);
    // byte mode
    send(16'h00FF, 16'h0001, 1'b0, 1'b1);
    send(16'h0080, 16'h0001, 1'b1, 1'b1);
    send(16'hAB05, 16'hCD03, 1'b0, 1'b1);
    send(16'h0000, 16'h0001, 1'b1, 1'b1);
    send(16'h127F, 16'h3401, 1'b0, 1'b1);
    drain();

    // R8: operand pins wiggle without a transfer
    sw0 = status_word;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      op_a = 16'hFFFF - 16'(i); op_b = 16'h0001; op_sub = i[0];
    end
    @(negedge clk);
    chk("R8 flags held without transfer", status_word, sw0);
    chk("R8 held value matches last op", status_word, last_cond | {5'h0, ctl_model, 8'h0});

    // R9 control flags
    ctl(3'b011, 3'b000);
    chk("R9 set single-step and interrupt", {13'h0, status_word[10:8]}, 16'h0003);
    send(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    send(16'h0001, 16'h0002, 1'b1, 1'b0);
    drain();
    chk("R9 arithmetic keeps control bits", {13'h0, status_word[10:8]}, 16'h0003);
    ctl(3'b100, 3'b100);
    chk("R9 clear wins over set", {13'h0, status_word[10:8]}, 16'h0003);
    ctl(3'b100, 3'b010);
    chk("R9 set direction clear interrupt", {13'h0, status_word[10:8]}, 16'h0005);

    // R10 stall
    @(negedge clk) res_ready = 1'b0;
    send(16'h1111, 16'h2222, 1'b0, 1'b0);
    #3;
    chk("R10 valid during stall", {15'h0, res_valid}, 16'h1);
    chk("R10 ready low during stall", {15'h0, op_ready}, 16'h0);
    held = res_data;
    repeat (3) @(negedge clk);
    #3;
    chk("R10 data held during stall", res_data, held);
    chk("R10 still refusing", {15'h0, op_ready}, 16'h0);
    @(negedge clk) res_ready = 1'b1;
    drain();

    // random back-pressure burst
    rand_bp = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(16'(i * 16'h0F3B + 16'h1357), 16'(i * 16'h2A61 + 16'h00C9), i[0], i[1] & i[2]);
    end
    rand_bp = 1'b0;
    @(negedge clk) res_ready = 1'b1;
    drain();
    chk("R1 scoreboard empty", 16'(q.size()), 16'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule